// File: doc/BRIEF.md
# Non-Restoring Signed Fraction Divider

This block divides one signed two's-complement fraction by another. It produces one quotient bit per clock and never restores the partial remainder. Each operand is `W` bits wide. The top bit is the sign, to the left of the binary point, so an operand word `v` stands for the value `signed(v) / 2^(W-1)`.

A single-cycle `start_i` pulse captures the operands. The first step combines the dividend with the divisor. When their sign bits match, the divisor is subtracted; otherwise it is added. Each of the following `W-1` steps reads one quotient bit from a sign comparison, doubles the partial remainder, and then subtracts or adds the divisor. The least significant quotient bit is then set to 1 with no correction pass, so the remainder left behind may be negative.

The block raises an error flag when the operand magnitudes do not satisfy |dividend| < |divisor|, and this includes a zero divisor. The timing of the result pulse is the same whether or not the error flag is raised.

Top module: `fdiv_nonrestore`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle and drives `busy_o`, `done_o`, `err_o`, `quot_o` and `rem_o` to zero.
- R2: `done_o` is high for exactly one cycle. It rises after the W+1-th rising edge that follows the edge that accepted `start_i`. `busy_o` is high from the accepting edge until that point, and it is low while `done_o` is high.
- R3: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running division completes on schedule with its original operands, and no additional `done_o` pulse follows.
- R4: First step: with dividend X and divisor Y as signed integers, r0 = X - Y when their sign bits are equal and r0 = X + Y when they differ. For W=4 and Y=6, X=4 gives r0=-2 and X=-4 gives r0=2.
- R5: Each later step produces a quotient bit from left to right, starting at the sign bit. The bit is 1 and r becomes 2r - Y when r has the sign of Y (zero counts as positive). Otherwise the bit is 0 and r becomes 2r + Y. For W=4: (4,6) gives quotient 4'b0101 with remainder 2, (4,-6) gives 4'b1011 with 2, (-4,6) gives 4'b1011 with -2, and (-4,-6) gives 4'b0101 with -2.
- R6: On every result, bit 0 of `quot_o` is 1.
- R7: When `err_o` is low, X·2^(W-1) = Q·Y + R holds exactly. Here Q is `quot_o` read as a signed integer and R is `rem_o` read as a W+1-bit signed integer.
- R8: When `err_o` is low, |R| ≤ |Y|. The quotient therefore lies within 2^-(W-1) of the true ratio.
- R9: `err_o` is 1 with the result exactly when |X| ≥ |Y|, which includes Y = 0 and X = -2^(W-1). The `done_o` pulse still appears on the R2 schedule.
- R10: `quot_o`, `rem_o` and `err_o` change only in the cycle in which `done_o` is high, and they hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| dividend_i | input | W | Signed fraction numerator |
| divisor_i | input | W | Signed fraction denominator |
| quot_o | output | W | Signed fraction quotient, bit 0 forced to 1 |
| rem_o | output | W+1 | Final partial remainder, signed, not corrected |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Magnitude precondition failed for this result |

## Verification
The bench instantiates the block twice, once with W=4 and once with the default W=8.

The 4-bit copy is small enough to sweep every one of the 256 operand pairs. That sweep reaches every sign combination, the zero divisor, the most negative dividend and divisor, and every equal-magnitude pair. It also provides hand-derived quotient and remainder words for the sign rules.

The 8-bit copy adds random operand pairs and extreme values such as a divisor of -1.0 with a dividend of 127/128. It also runs the start-while-busy and hold-between-results scenarios at the default width.

// File: rtl/fdiv_pkg.sv
// Package fdiv_pkg
// Shared types for the non-restoring fraction divider.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fdiv_pkg;

    // Sequencer phases: idle, first combine, bit iterations, result write.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_ITER = 2'd2,
        ST_FIN  = 2'd3
    } fdiv_state_e;

endpackage

// File: rtl/fdiv_step.sv
// Module fdiv_step
// One combinational step of non-restoring division. The step compares the
// sign of the operand with the sign of the divisor, optionally doubles the
// operand, and subtracts the divisor on a sign match or adds it otherwise.
// Assumes |operand| <= |divisor| and a divisor sign-extended by one bit.
// The arithmetic is modulo 2^(W+1), so the doubled value may wrap but the
// final sum is always back in range.
module fdiv_step #(
    parameter int W = 8
) (
    input  logic [W:0]   operand_i,
    input  logic [W-1:0] divisor_i,
    input  logic         shift_i,
    output logic         same_sign_o,
    output logic [W:0]   result_o
);

    logic [W:0] div_ext;
    logic [W:0] base;

    // Sign-extend the divisor and pick the doubled or plain operand.
    always_comb begin
        div_ext     = {divisor_i[W-1], divisor_i};
        base        = shift_i ? {operand_i[W-1:0], 1'b0} : operand_i;
        same_sign_o = (operand_i[W] == divisor_i[W-1]);
        result_o    = same_sign_o ? (base - div_ext) : (base + div_ext);
    end

endmodule

// File: rtl/fdiv_range.sv
// Module fdiv_range
// Magnitude precondition check: in_range_o is high when |dividend| is
// strictly below |divisor|. A zero divisor is therefore always out of
// range. Magnitudes are formed in W+1 bits so that -2^(W-1) is exact.
module fdiv_range #(
    parameter int W = 8
) (
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         in_range_o
);

    logic [W:0] x_ext, y_ext, x_mag, y_mag;

    // Build unsigned magnitudes and compare them.
    always_comb begin
        x_ext      = {dividend_i[W-1], dividend_i};
        y_ext      = {divisor_i[W-1], divisor_i};
        x_mag      = dividend_i[W-1] ? (~x_ext + 1'b1) : x_ext;
        y_mag      = divisor_i[W-1]  ? (~y_ext + 1'b1) : y_ext;
        in_range_o = (x_mag < y_mag);
    end

    // R9: a zero divisor can never pass the range check.
    always_comb begin
        if (divisor_i == '0) begin
            p_zero_div_r9: assert (!in_range_o)
                else $error("zero divisor reported in range");
        end
    end

endmodule

// File: rtl/fdiv_ctrl.sv
// Module fdiv_ctrl
// Sequencer for the divider. It accepts a start only while idle, spends
// one cycle on the first combine, W-1 cycles on bit iterations, and one
// cycle writing the result, so the result appears W+1 edges after the
// accepting edge. Assumes W >= 3 and a synchronous active-low reset.
module fdiv_ctrl
    import fdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic init_o,
    output logic iter_o,
    output logic fin_o,
    output logic busy_o
);

    localparam int CW        = $clog2(W);
    localparam int ITER_LAST = W - 2;
    localparam int LW        = $clog2(W + 3) + 1;

    fdiv_state_e   state;
    logic [CW-1:0] iter_cnt;

    // Decode the phase strobes from the current state.
    always_comb begin
        accept_o = (state == ST_IDLE) && start_i;
        init_o   = (state == ST_INIT);
        iter_o   = (state == ST_ITER);
        fin_o    = (state == ST_FIN);
        busy_o   = (state != ST_IDLE);
    end

    // Advance the phase and count the bit iterations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            iter_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_i) state <= ST_INIT;
                ST_INIT: begin
                    state    <= ST_ITER;
                    iter_cnt <= '0;
                end
                ST_ITER: begin
                    if (iter_cnt == CW'(ITER_LAST)) begin
                        state    <= ST_FIN;
                        iter_cnt <= '0;
                    end else begin
                        iter_cnt <= iter_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Latency counter used only by the checks below.
    logic [LW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)        lat_cnt <= '0;
        else if (accept_o) lat_cnt <= LW'(1);
        else if (busy_o)   lat_cnt <= lat_cnt + 1'b1;
    end

    // R2: the result phase is entered exactly W+1 edges after acceptance.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> (lat_cnt == LW'(W + 1)))
        else $error("result phase at wrong latency");

    // R2: the result phase lasts one cycle and is followed by idle.
    p_fin_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !busy_o)
        else $error("result phase not followed by idle");

    // R3: a running division is never restarted.
    p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !init_o || $past(init_o) == 1'b0 && !busy_o == 1'b0 && state != ST_INIT)
        else $error("restart while busy");

endmodule

// File: rtl/fdiv_nonrestore.sv
// Module fdiv_nonrestore
// Top of the non-restoring signed fraction divider. It captures the
// operands on an accepted start, runs the first combine and W-1 bit
// iterations through one shared step unit, forces the last quotient bit
// to 1, and publishes quotient, remainder and error together with a
// one-cycle done pulse. Operands are W-bit two's-complement fractions.
// Assumes W >= 3.
module fdiv_nonrestore #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic [W:0]   rem_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         err_o
);

    localparam int QB = W - 1;
    localparam int PW = 2 * W + 2;

    logic accept, init_ph, iter_ph, fin_ph;
    logic in_range;
    logic same_sign;
    logic [W:0]    step_in, step_out;
    logic [W-1:0]  x_q, y_q;
    logic [W:0]    r_q;
    logic [QB-1:0] qbits;
    logic          err_q;

    fdiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .init_o   (init_ph),
        .iter_o   (iter_ph),
        .fin_o    (fin_ph),
        .busy_o   (busy_o)
    );

    fdiv_range #(.W(W)) u_range (
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .in_range_o (in_range)
    );

    // Feed the step unit: the dividend in the first phase, the remainder afterwards.
    always_comb begin
        step_in = init_ph ? {x_q[W-1], x_q} : r_q;
    end

    fdiv_step #(.W(W)) u_step (
        .operand_i   (step_in),
        .divisor_i   (y_q),
        .shift_i     (iter_ph),
        .same_sign_o (same_sign),
        .result_o    (step_out)
    );

    // Capture operands and the precondition on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            err_q <= 1'b0;
        end else if (accept) begin
            x_q   <= dividend_i;
            y_q   <= divisor_i;
            err_q <= !in_range;
        end
    end

    // Update the partial remainder and shift in quotient bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q   <= '0;
            qbits <= '0;
        end else if (init_ph) begin
            r_q   <= step_out;
            qbits <= '0;
        end else if (iter_ph) begin
            r_q   <= step_out;
            qbits <= (qbits << 1) | QB'(same_sign);
        end
    end

    // Publish the result and pulse done in the result phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_o <= '0;
            rem_o  <= '0;
            err_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= fin_ph;
            if (fin_ph) begin
                quot_o <= {qbits, 1'b1};
                rem_o  <= r_q;
                err_o  <= err_q;
            end
        end
    end

    // Signed views of the held operands and result for the checks below.
    logic signed [PW-1:0] a_lhs, a_rhs, a_rmag, a_ymag;
    always_comb begin
        a_lhs  = PW'($signed(x_q)) <<< (W - 1);
        a_rhs  = PW'($signed(quot_o)) * PW'($signed(y_q)) + PW'($signed(rem_o));
        a_rmag = rem_o[W] ? -PW'($signed(rem_o)) : PW'($signed(rem_o));
        a_ymag = y_q[W-1] ? -PW'($signed(y_q)) : PW'($signed(y_q));
    end

    // R6: the least significant quotient bit is set on every result.
    p_lsb_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> quot_o[0])
        else $error("quotient lsb not set");

    // R7: dividend equals quotient times divisor plus remainder.
    p_identity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (a_lhs == a_rhs))
        else $error("division identity broken");

    // R8: the remainder magnitude never exceeds the divisor magnitude.
    p_rem_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (a_rmag <= a_ymag))
        else $error("remainder out of bound");

    // R2: done is a single-cycle pulse with busy already low.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o ##1 !done_o)
        else $error("done not a clean pulse");

    // R3: captured operands stay fixed while a division runs.
    p_capture_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(x_q) && $stable(y_q)))
        else $error("operands changed while busy");

    // R10: results only move in the done cycle.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(err_o)))
        else $error("result changed outside done");

endmodule

// File: tb/fdiv_nonrestore_tb.sv
// Directed bench for fdiv_nonrestore: one W=4 copy swept exhaustively and
// one W=8 copy for random, extreme and sequencing scenarios.
module fdiv_nonrestore_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;

    logic       s8 = 1'b0;
    logic [7:0] x8 = '0, y8 = '0;
    logic [7:0] q8;
    logic [8:0] r8;
    logic       b8, d8, e8;

    logic       s4 = 1'b0;
    logic [3:0] x4 = '0, y4 = '0;
    logic [3:0] q4;
    logic [4:0] r4;
    logic       b4, d4, e4;

    int n_chk = 0;
    int n_err = 0;

    fdiv_nonrestore #(.W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(s8), .dividend_i(x8), .divisor_i(y8),
        .quot_o(q8), .rem_o(r8), .busy_o(b8), .done_o(d8), .err_o(e8)
    );

    fdiv_nonrestore #(.W(4)) u_dut_w4 (
        .clk(clk), .rst_n(rst_n), .start_i(s4), .dividend_i(x4), .divisor_i(y4),
        .quot_o(q4), .rem_o(r4), .busy_o(b4), .done_o(d4), .err_o(e4)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Run one division on the 8-bit copy; lat counts edges after acceptance.
    task automatic run8(input logic [7:0] x, input logic [7:0] y,
                        output longint q, output longint r, output bit e, output int lat);
        @(negedge clk); x8 = x; y8 = y; s8 = 1'b1;
        @(negedge clk); s8 = 1'b0;
        lat = 0;
        while (!d8 && lat < 40) begin @(negedge clk); lat++; end
        q = longint'($signed(q8)); r = longint'($signed(r8)); e = e8;
    endtask

    // Run one division on the 4-bit copy.
    task automatic run4(input logic [3:0] x, input logic [3:0] y,
                        output longint q, output longint r, output bit e, output int lat);
        @(negedge clk); x4 = x; y4 = y; s4 = 1'b1;
        @(negedge clk); s4 = 1'b0;
        lat = 0;
        while (!d4 && lat < 40) begin @(negedge clk); lat++; end
        q = longint'($signed(q4)); r = longint'($signed(r4)); e = e4;
    endtask

    // Check one result against the requirements from the operand values alone.
    task automatic judge(input int w, input longint x, input longint y,
                         input longint q, input longint r, input bit e, input int lat);
        longint ax, ay, ar, s;
        bit exp_err;
        ax = (x < 0) ? -x : x;
        ay = (y < 0) ? -y : y;
        ar = (r < 0) ? -r : r;
        s  = longint'(1) << (w - 1);
        exp_err = !(ax < ay);
        chk(lat == w + 1, "R2 done latency", lat, w + 1);
        chk(e == exp_err, "R9 error flag", e, exp_err);
        if (!exp_err) begin
            chk((q & 1) == 1, "R6 quotient lsb", q & 1, 1);
            chk(x * s == q * y + r, "R7 identity x*2^(W-1) vs q*y+r", q * y + r, x * s);
            chk(ar <= ay, "R8 remainder magnitude", ar, ay);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!b8 && !d8 && !e8, "R1 control outputs in reset", {b8, d8, e8}, 0);
        chk(q8 == 0 && r8 == 0, "R1 data outputs in reset", q8, 0);
        chk(!b4 && !d4 && q4 == 0 && r4 == 0, "R1 small copy in reset", q4, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!b8 && !d8 && q8 == 0, "R1 idle after release", b8, 0);
    endtask

    // Hand-worked W=4 vectors for the first-step and per-bit sign rules.
    task automatic t_sign_rules();
        longint q, r; bit e; int lat;
        run4(4'sd4, 4'sd6, q, r, e, lat);
        chk(q == 5 && r == 2, "R4 R5 (+,+) quotient/remainder", q * 100 + r, 502);
        run4(4'sd4, -4'sd6, q, r, e, lat);
        chk(q == -5 && r == 2, "R4 R5 (+,-) quotient/remainder", q * 100 + r, -498);
        run4(-4'sd4, 4'sd6, q, r, e, lat);
        chk(q == -5 && r == -2, "R4 R5 (-,+) quotient/remainder", q * 100 + r, -502);
        run4(-4'sd4, -4'sd6, q, r, e, lat);
        chk(q == 5 && r == -2, "R4 R5 (-,-) quotient/remainder", q * 100 + r, 498);
        judge(4, -4, -6, q, r, e, lat);
    endtask

    task automatic t_sweep_w4();
        longint q, r; bit e; int lat;
        for (int xi = -8; xi < 8; xi++) begin
            for (int yi = -8; yi < 8; yi++) begin
                run4(4'(xi), 4'(yi), q, r, e, lat);
                judge(4, xi, yi, q, r, e, lat);
            end
        end
    endtask

    task automatic t_extremes_w8();
        longint q, r; bit e; int lat;
        run8(8'h7F, 8'h80, q, r, e, lat); judge(8, 127, -128, q, r, e, lat);
        run8(8'h80, 8'h80, q, r, e, lat); judge(8, -128, -128, q, r, e, lat);
        run8(8'h10, 8'h00, q, r, e, lat); judge(8, 16, 0, q, r, e, lat);
        chk(e == 1'b1, "R9 zero divisor flagged", e, 1);
        run8(8'h00, 8'h00, q, r, e, lat); judge(8, 0, 0, q, r, e, lat);
        run8(8'h00, 8'h81, q, r, e, lat); judge(8, 0, -127, q, r, e, lat);
        run8(8'hC0, 8'h40, q, r, e, lat); judge(8, -64, 64, q, r, e, lat);
        run8(8'h01, 8'h7F, q, r, e, lat); judge(8, 1, 127, q, r, e, lat);
    endtask

    task automatic t_random_w8();
        longint q, r; bit e; int lat;
        for (int i = 0; i < 400; i++) begin
            logic [7:0] xr, yr;
            xr = 8'($urandom);
            yr = 8'($urandom);
            if (i % 2 == 0) xr = 8'($signed(xr) >>> 2);
            run8(xr, yr, q, r, e, lat);
            judge(8, longint'($signed(xr)), longint'($signed(yr)), q, r, e, lat);
        end
    endtask

    // A second start during a running division must be ignored.
    task automatic t_start_while_busy();
        int lat = 0;
        int extra = 0;
        longint q, r;
        @(negedge clk); x8 = 8'h30; y8 = 8'hA0; s8 = 1'b1;
        @(negedge clk); s8 = 1'b0;
        @(negedge clk); lat = 1;
        x8 = 8'h05; y8 = 8'h70; s8 = 1'b1;
        chk(b8 == 1'b1, "R2 busy during division", b8, 1);
        @(negedge clk); s8 = 1'b0; lat = 2;
        while (!d8 && lat < 40) begin @(negedge clk); lat++; end
        q = longint'($signed(q8)); r = longint'($signed(r8));
        chk(lat == 9, "R3 latency unchanged by ignored start", lat, 9);
        chk(!b8, "R2 busy low with done", b8, 0);
        judge(8, 48, -96, q, r, e8, lat);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (d8) extra++;
        end
        chk(extra == 0, "R3 no result for ignored start", extra, 0);
    endtask

    // Results hold while inputs move without a start.
    task automatic t_hold();
        longint q, r; bit e; int lat;
        logic [7:0] hq; logic [8:0] hr; logic he;
        int moved = 0;
        run8(8'hE0, 8'h50, q, r, e, lat);
        judge(8, -32, 80, q, r, e, lat);
        hq = q8; hr = r8; he = e8;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            x8 = 8'($urandom); y8 = 8'($urandom);
            if (q8 != hq || r8 != hr || e8 != he || d8) moved++;
        end
        chk(moved == 0, "R10 outputs held without start", moved, 0);
    endtask

    initial begin
        t_reset();
        t_sign_rules();
        t_sweep_w4();
        t_extremes_w8();
        t_random_w8();
        t_start_while_busy();
        t_hold();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule